// File: doc/BRIEF.md
# PLL Bring-Up Power Sequencer

This block is a hardware state machine that takes a main PLL and a peripheral PLL from whatever state they were left in to locked, running outputs. It assumes nothing about that prior state. A pulse on `start` makes it walk through one fixed sequence. First it gates the software-managed clocks and forces both PLLs into bypass. It then returns the VCO controls to their reset values, clears the sticky status flags and loads the fractional setting. Two timed power-up waits follow. After them it enables the VCOs, loads the dividers and waits for both lock flags. Once lock is seen it pulses each output reset, releases bypass under a busy handshake, runs an optional frequency ramp, and finally ungates the clocks. `done` pulses when the sequence is complete.

The microsecond waits are counted on an external `us_tick` strobe. The count is built so that no wait can be shorter than its programmed number of microseconds, even when a tick falls right at the start of the wait. Waiting for lock or for the ramp is bounded by a cycle timeout, and so is each wait for not-busy. If a timeout expires, the machine raises `error` and parks in a fault state, with both PLLs in bypass and the clocks gated, until it is reset. Bit 0 of every two-bit control output belongs to the main PLL and bit 1 to the peripheral PLL. The analog PLLs, the divider values and the ramp arithmetic are outside this block.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, and again after a completed sequence, the outputs show the running state: `clk_en`=2'b11, `bypass`=2'b00, `pwrdn`=`bgpwrdn`=2'b00, `regext`=2'b00, `vco_en`=2'b11, `outrst`=2'b00, all pulse outputs low, `done`=0, `error`=0.
- R2: One cycle after `start` is sampled in idle, `clk_en[0]` drops. `clk_en[1]` drops one cycle after that, and `bypass` becomes 2'b11 one cycle after that.
- R3: The cycle after bypass is forced, `vco_rst` pulses while `pwrdn`, `bgpwrdn` and `regext` rise to 2'b11 and `vco_en` falls to 2'b00. `flag_clr_all` pulses in the next cycle and `frac_load` in the cycle after it.
- R4: `pwrdn` and `bgpwrdn` fall on the clock edge that samples the (PWR_US+1)-th `us_tick` after the `frac_load` cycle. Ticks sampled during the `frac_load` cycle are not counted.
- R5: `vco_en` rises to 2'b11 and `regext` falls to 2'b00 on the edge that samples the (VCO_US+1)-th `us_tick` after `pwrdn` fell.
- R6: `div_load` pulses in the cycle right after the VCOs are enabled. The machine then waits until `main_lock` and `per_lock` are both high.
- R7: Once both locks are sampled high, `outrst[0]` pulses for one cycle. `outrst[1]` pulses in the next cycle, and the two pulses never overlap.
- R8: `bypass[0]` falls in the cycle after the `outrst[1]` pulse. `bypass[1]` falls on the first edge at least two cycles later that samples `busy` low. `boot_clr` pulses under the same rule after that. The next step follows under the same rule after the `boot_clr` pulse.
- R9: With `ramp_en`=1, `ramp_go` is held high after the boot wait until `ramp_done` is sampled high, and the clocks are ungated in that same edge. With `ramp_en`=0, `ramp_go` stays low and the clocks are ungated directly after the boot wait.
- R10: `clk_en` returns to 2'b11 in one step. `flag_clr_fault` pulses in the next cycle and `done` pulses for one cycle after that, and the machine is back in idle.
- R11: If the locks are not both high, or `ramp_done` is not seen, within LOCK_TMO cycles of entering the wait, `error` rises LOCK_TMO cycles after the wait began.
- R12: If `busy` stays high for BUSY_TMO cycles of a bypass or boot wait, `error` rises BUSY_TMO cycles after the wait began.
- R13: In the fault state, `bypass`=2'b11, `clk_en`=2'b00 and `error`=1 hold until reset, and `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the sequence when sampled in idle |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| main_lock | input | 1 | Main PLL lock flag |
| per_lock | input | 1 | Peripheral PLL lock flag |
| busy | input | 1 | Clock network busy after a bypass or boot-mode change |
| ramp_en | input | 1 | Static: a frequency ramp is required |
| ramp_done | input | 1 | Ramp finished |
| clk_en | output | 2 | Software-managed clock enables |
| bypass | output | 2 | PLL bypass |
| pwrdn | output | 2 | PLL power-down |
| bgpwrdn | output | 2 | Bandgap power-down |
| regext | output | 2 | External regulator select |
| vco_en | output | 2 | VCO enable |
| outrst | output | 2 | Output reset-all pulse |
| vco_rst | output | 1 | Return VCO controls to reset values |
| flag_clr_all | output | 1 | Clear all sticky flags, including lock achieved |
| frac_load | output | 1 | Load numerator and denominator |
| div_load | output | 1 | Load internal and external dividers |
| boot_clr | output | 1 | Clear boot mode |
| ramp_go | output | 1 | Run the frequency ramp |
| flag_clr_fault | output | 1 | Clear lock-lost and slip flags |
| done | output | 1 | Sequence complete pulse |
| error | output | 1 | Timeout fault |

## Verification
The full sequence is run with several configurations: ramp on and ramp off, lock delays that differ between the two PLLs, and busy pulses of zero, one, three and six cycles. Comparing the busy lengths shows that the busy wait can stretch beyond its two-cycle minimum but is never shorter. Comparing ramp on and ramp off shows that the ramp is inserted between the boot wait and ungating. The tick counts inside both power-up windows are exact, which tells an off-by-one tick count apart from a correct minimum. Two further runs, one where lock never arrives and one where busy sticks high, check that each timeout fires on its exact cycle and that the fault state holds.

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
  parameter int PWR_US   = 5,
  parameter int VCO_US   = 7,
  parameter int LOCK_TMO = 4096,
  parameter int BUSY_TMO = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       us_tick,
  input  logic       main_lock,
  input  logic       per_lock,
  input  logic       busy,
  input  logic       ramp_en,
  input  logic       ramp_done,
  output logic [1:0] clk_en,
  output logic [1:0] bypass,
  output logic [1:0] pwrdn,
  output logic [1:0] bgpwrdn,
  output logic [1:0] regext,
  output logic [1:0] vco_en,
  output logic [1:0] outrst,
  output logic       vco_rst,
  output logic       flag_clr_all,
  output logic       frac_load,
  output logic       div_load,
  output logic       boot_clr,
  output logic       ramp_go,
  output logic       flag_clr_fault,
  output logic       done,
  output logic       error
);

  localparam int M1   = (LOCK_TMO > BUSY_TMO) ? LOCK_TMO : BUSY_TMO;
  localparam int M2   = (PWR_US > VCO_US) ? PWR_US : VCO_US;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_GATE_M, S_GATE_P, S_BYP, S_VCORST, S_CLR, S_FRAC,
    S_WAIT_PWR, S_WAIT_VCO, S_VCO_EN, S_DIV, S_LOCK, S_ORST_M, S_ORST_P,
    S_REL_M, S_WB_M, S_REL_P, S_WB_P, S_BOOT, S_WB_B, S_RAMP,
    S_UNGATE, S_CLR2, S_DONE, S_FAULT
  } st_t;

  st_t st_q, st_d;
  logic [CW-1:0] cnt;

  wire locked     = main_lock && per_lock;
  wire tick_wait  = (st_q == S_WAIT_PWR) || (st_q == S_WAIT_VCO);
  wire timed_wait = (st_q == S_LOCK) || (st_q == S_RAMP) ||
                    (st_q == S_WB_M) || (st_q == S_WB_P) || (st_q == S_WB_B);
  wire lock_exp   = cnt == CW'(LOCK_TMO - 1);
  wire busy_exp   = cnt == CW'(BUSY_TMO - 1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:     if (start) st_d = S_GATE_M;
      S_GATE_M:   st_d = S_GATE_P;
      S_GATE_P:   st_d = S_BYP;
      S_BYP:      st_d = S_VCORST;
      S_VCORST:   st_d = S_CLR;
      S_CLR:      st_d = S_FRAC;
      S_FRAC:     st_d = S_WAIT_PWR;
      S_WAIT_PWR: if (us_tick && cnt == CW'(PWR_US)) st_d = S_WAIT_VCO;
      S_WAIT_VCO: if (us_tick && cnt == CW'(VCO_US)) st_d = S_VCO_EN;
      S_VCO_EN:   st_d = S_DIV;
      S_DIV:      st_d = S_LOCK;
      S_LOCK:     if (locked) st_d = S_ORST_M;
                  else if (lock_exp) st_d = S_FAULT;
      S_ORST_M:   st_d = S_ORST_P;
      S_ORST_P:   st_d = S_REL_M;
      S_REL_M:    st_d = S_WB_M;
      S_WB_M:     if (!busy) st_d = S_REL_P;
                  else if (busy_exp) st_d = S_FAULT;
      S_REL_P:    st_d = S_WB_P;
      S_WB_P:     if (!busy) st_d = S_BOOT;
                  else if (busy_exp) st_d = S_FAULT;
      S_BOOT:     st_d = S_WB_B;
      S_WB_B:     if (!busy) st_d = ramp_en ? S_RAMP : S_UNGATE;
                  else if (busy_exp) st_d = S_FAULT;
      S_RAMP:     if (ramp_done) st_d = S_UNGATE;
                  else if (lock_exp) st_d = S_FAULT;
      S_UNGATE:   st_d = S_CLR2;
      S_CLR2:     st_d = S_DONE;
      S_DONE:     st_d = S_IDLE;
      S_FAULT:    st_d = S_FAULT;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      cnt  <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) cnt <= '0;
      else if (tick_wait) cnt <= cnt + CW'(us_tick);
      else if (timed_wait) cnt <= cnt + 1'b1;
    end
  end

  wire in_pwr  = st_d >= S_VCORST && st_d <= S_WAIT_PWR;
  wire in_reg  = st_d >= S_VCORST && st_d <= S_WAIT_VCO;
  wire fault_d = st_d == S_FAULT;

  logic [1:0] clk_en_d, bypass_d;
  assign clk_en_d[0] = !(fault_d || (st_d >= S_GATE_M && st_d <= S_RAMP));
  assign clk_en_d[1] = !(fault_d || (st_d >= S_GATE_P && st_d <= S_RAMP));
  assign bypass_d[0] = fault_d || (st_d >= S_BYP && st_d <= S_ORST_P);
  assign bypass_d[1] = fault_d || (st_d >= S_BYP && st_d <= S_WB_M);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en         <= 2'b11;
      bypass         <= 2'b00;
      pwrdn          <= 2'b00;
      bgpwrdn        <= 2'b00;
      regext         <= 2'b00;
      vco_en         <= 2'b11;
      outrst         <= 2'b00;
      vco_rst        <= 1'b0;
      flag_clr_all   <= 1'b0;
      frac_load      <= 1'b0;
      div_load       <= 1'b0;
      boot_clr       <= 1'b0;
      ramp_go        <= 1'b0;
      flag_clr_fault <= 1'b0;
      done           <= 1'b0;
      error          <= 1'b0;
    end else begin
      clk_en         <= clk_en_d;
      bypass         <= bypass_d;
      pwrdn          <= {2{in_pwr}};
      bgpwrdn        <= {2{in_pwr}};
      regext         <= {2{in_reg}};
      vco_en         <= {2{!in_reg}};
      outrst         <= {st_d == S_ORST_P, st_d == S_ORST_M};
      vco_rst        <= st_d == S_VCORST;
      flag_clr_all   <= st_d == S_CLR;
      frac_load      <= st_d == S_FRAC;
      div_load       <= st_d == S_DIV;
      boot_clr       <= st_d == S_BOOT;
      ramp_go        <= st_d == S_RAMP;
      flag_clr_fault <= st_d == S_CLR2;
      done           <= st_d == S_DONE;
      error          <= fault_d;
    end
  end

endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       main_lock,
  input logic       per_lock,
  input logic [1:0] clk_en,
  input logic [1:0] bypass,
  input logic [1:0] pwrdn,
  input logic [1:0] regext,
  input logic [1:0] vco_en,
  input logic [1:0] outrst,
  input logic       flag_clr_all,
  input logic       frac_load,
  input logic       div_load,
  input logic       ramp_go,
  input logic       done,
  input logic       error
);

  p_gate_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en[1]) |-> !clk_en[0]);

  p_frac_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frac_load) |-> $past(flag_clr_all));

  p_vco_after_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_en[0]) |-> pwrdn == 2'b00 && regext == 2'b00);

  p_div_with_vco_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |-> vco_en == 2'b11 && pwrdn == 2'b00);

  p_orst_after_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outrst[0]) |-> $past(main_lock && per_lock));

  p_orst_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outrst[1]) |-> $past(outrst[0]));

  p_orst_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(outrst));

  p_bypass_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass[1]) |-> !bypass[0] && $past(!busy));

  p_ramp_before_ungate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en[0]) |-> !ramp_go && bypass == 2'b00);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && bypass == 2'b11 && clk_en == 2'b00);

endmodule

bind pll_bringup_seq pll_bringup_seq_chk u_chk (.*);

// File: tb/test_pll_bringup_seq.sv
module test_pll_bringup_seq;
  localparam int PWR_US = 5, VCO_US = 7, LOCK_TMO = 4096, BUSY_TMO = 256;
  localparam int NV = 6;
  // ramp_en, lock delay, busy length, mode (0 ok, 1 lock timeout, 2 busy timeout)
  localparam int VEC [NV][4] = '{
    '{0, 20, 3, 0}, '{1, 40, 0, 0}, '{0, 5, 1, 0},
    '{1, 10, 6, 0}, '{0, 99999, 2, 1}, '{1, 15, 100000, 2}};

  logic clk = 0, rst_n = 0, start = 0, us_tick = 0;
  logic main_lock = 0, per_lock = 0, busy = 0, ramp_en = 0, ramp_done = 0;
  logic [1:0] clk_en, bypass, pwrdn, bgpwrdn, regext, vco_en, outrst;
  logic vco_rst, flag_clr_all, frac_load, div_load, boot_clr, ramp_go, flag_clr_fault, done, error;

  pll_bringup_seq #(.PWR_US(PWR_US), .VCO_US(VCO_US), .LOCK_TMO(LOCK_TMO), .BUSY_TMO(BUSY_TMO))
  i_pll_bringup_seq (.*);

  always #5 clk = ~clk;

  int nerr = 0, nchk = 0, cyc = 0;
  int lock_dly = 0, busy_len = 0;
  int tdiv = 0, lc0 = 0, lc1 = 0, bcnt = 0, rcnt = 0;
  logic [1:0] p_byp = 0; logic p_boot = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == 9) ? 0 : tdiv + 1;
    us_tick = (tdiv == 9);
    if (pwrdn[0] || !vco_en[0]) begin lc0 = 0; main_lock = 0; end
    else if (lc0 >= lock_dly) main_lock = 1; else lc0++;
    if (pwrdn[1] || !vco_en[1]) begin lc1 = 0; per_lock = 0; end
    else if (lc1 >= lock_dly + 3) per_lock = 1; else lc1++;
    if (((p_byp & ~bypass) != 0 || (boot_clr && !p_boot)) && busy_len > 0) bcnt = busy_len;
    else if (bcnt > 0) bcnt--;
    busy = bcnt > 0;
    p_byp = bypass; p_boot = boot_clr;
    if (ramp_go) rcnt++; else rcnt = 0;
    ramp_done = rcnt >= 8;
  end

  int t_gm, t_gp, t_byp, t_vrst, t_pwon, t_clr, t_frac, t_pwr, t_vco, t_div;
  int t_orm, t_orp, t_relm, t_relp, t_boot, t_rampon, t_ung, t_clr2, t_done, t_err;
  int n_pw, n_vw; logic lk_orm;
  logic [1:0] q_clk = 2'b11, q_byp = 0, q_pwr = 0, q_vco = 2'b11, q_orst = 0;
  logic q_vr = 0, q_ramp = 0, q_err = 0;

  task automatic clear_stamps();
    t_gm = -1; t_gp = -1; t_byp = -1; t_vrst = -1; t_pwon = -1; t_clr = -1;
    t_frac = -1; t_pwr = -1; t_vco = -1; t_div = -1; t_orm = -1; t_orp = -1;
    t_relm = -1; t_relp = -1; t_boot = -1; t_rampon = -1; t_ung = -1;
    t_clr2 = -1; t_done = -1; t_err = -1; n_pw = 0; n_vw = 0; lk_orm = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (q_clk[0] && !clk_en[0] && t_gm < 0) t_gm = cyc;
      if (q_clk[1] && !clk_en[1] && t_gp < 0) t_gp = cyc;
      if (q_byp != 2'b11 && bypass == 2'b11 && t_byp < 0) t_byp = cyc;
      if (!q_vr && vco_rst && t_vrst < 0) t_vrst = cyc;
      if (!q_pwr[0] && pwrdn[0] && t_pwon < 0) t_pwon = cyc;
      if (flag_clr_all && t_clr < 0) t_clr = cyc;
      if (frac_load && t_frac < 0) t_frac = cyc;
      if (t_frac >= 0 && !frac_load && pwrdn[0] && t_pwr < 0 && us_tick) n_pw++;
      if (pwrdn == 2'b00 && vco_en == 2'b00 && us_tick) n_vw++;
      if (q_pwr[0] && !pwrdn[0] && t_pwr < 0) t_pwr = cyc;
      if (!q_vco[0] && vco_en[0] && t_vco < 0) t_vco = cyc;
      if (div_load && t_div < 0) t_div = cyc;
      if (!q_orst[0] && outrst[0] && t_orm < 0) begin t_orm = cyc; lk_orm = main_lock && per_lock; end
      if (!q_orst[1] && outrst[1] && t_orp < 0) t_orp = cyc;
      if (q_byp[0] && !bypass[0] && t_relm < 0) t_relm = cyc;
      if (q_byp[1] && !bypass[1] && t_relp < 0) t_relp = cyc;
      if (boot_clr && t_boot < 0) t_boot = cyc;
      if (!q_ramp && ramp_go && t_rampon < 0) t_rampon = cyc;
      if (!q_clk[0] && clk_en[0] && t_ung < 0) t_ung = cyc;
      if (flag_clr_fault && t_clr2 < 0) t_clr2 = cyc;
      if (done && t_done < 0) t_done = cyc;
      if (!q_err && error && t_err < 0) t_err = cyc;
    end
    q_clk = clk_en; q_byp = bypass; q_pwr = pwrdn; q_vco = vco_en;
    q_orst = outrst; q_vr = vco_rst; q_ramp = ramp_go; q_err = error;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(clk_en == 2'b11 && bypass == 2'b00 && vco_en == 2'b11, req,
        {clk_en, bypass, vco_en}, 6'b110011);
    chk(pwrdn == 0 && bgpwrdn == 0 && regext == 0 && outrst == 0, req,
        {pwrdn, bgpwrdn, regext, outrst}, 0);
    chk(!done && !error && !vco_rst && !frac_load && !div_load && !ramp_go, req,
        {done, error, vco_rst, frac_load, div_load, ramp_go}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clear_stamps();
    do_reset();
    check_idle("R1 reset");

    for (int v = 0; v < NV; v++) begin
      int gap;
      ramp_en = VEC[v][0][0]; lock_dly = VEC[v][1]; busy_len = VEC[v][2];
      gap = (busy_len + 1 > 2) ? busy_len + 1 : 2;
      do_reset();
      clear_stamps();
      pulse_start();
      for (int w = 0; w < 20000 && t_done < 0 && t_err < 0; w++) @(negedge clk);
      chk(t_gp == t_gm + 1 && t_gm >= 0, "R2 gate order", t_gp - t_gm, 1);
      chk(t_byp == t_gp + 1, "R2 bypass", t_byp - t_gp, 1);
      chk(t_vrst == t_byp + 1 && t_pwon == t_vrst, "R3 vco reset", t_pwon - t_byp, 1);
      chk(t_clr == t_vrst + 1 && t_frac == t_clr + 1, "R3 clear/frac", t_frac - t_vrst, 2);
      chk(n_pw == PWR_US + 1, "R4 power wait ticks", n_pw, PWR_US + 1);
      chk(n_vw == VCO_US + 1, "R5 vco wait ticks", n_vw, VCO_US + 1);
      chk(t_div == t_vco + 1, "R6 divider load", t_div - t_vco, 1);
      if (VEC[v][3] == 1) begin
        chk(t_err == t_div + 1 + LOCK_TMO, "R11 lock timeout", t_err - t_div, 1 + LOCK_TMO);
        chk(t_orm < 0 && t_done < 0, "R11 no out reset", t_orm, -1);
      end else begin
        chk(lk_orm && t_orm > t_div, "R7 reset after lock", lk_orm, 1);
        chk(t_orp == t_orm + 1 && t_relm == t_orp + 1, "R7 reset order", t_relm - t_orm, 2);
      end
      if (VEC[v][3] == 2) begin
        chk(t_err == t_relm + 1 + BUSY_TMO, "R12 busy timeout", t_err - t_relm, 1 + BUSY_TMO);
        chk(t_relp < 0, "R12 peripheral held", t_relp, -1);
      end
      if (VEC[v][3] == 0) begin
        chk(t_relp == t_relm + gap, "R8 main-to-peripheral gap", t_relp - t_relm, gap);
        chk(t_boot == t_relp + gap, "R8 peripheral-to-boot gap", t_boot - t_relp, gap);
        if (ramp_en) begin
          chk(t_rampon == t_boot + gap, "R9 ramp start", t_rampon - t_boot, gap);
          chk(t_ung == t_rampon + 8, "R9 ramp end", t_ung - t_rampon, 8);
        end else begin
          chk(t_rampon < 0, "R9 ramp skipped", t_rampon, -1);
          chk(t_ung == t_boot + gap, "R9 direct ungate", t_ung - t_boot, gap);
        end
        chk(t_clr2 == t_ung + 1 && t_done == t_clr2 + 1, "R10 tail", t_done - t_ung, 2);
        @(negedge clk);
        check_idle("R10 back to idle");
      end else begin
        chk(error && bypass == 2'b11 && clk_en == 2'b00, "R13 fault outputs",
            {error, bypass, clk_en}, 5'b11100);
        pulse_start();
        repeat (10) @(negedge clk);
        chk(error && bypass == 2'b11 && clk_en == 2'b00 && t_done < 0, "R13 start ignored",
            {error, bypass, clk_en}, 5'b11100);
      end
    end

    busy_len = 0; lock_dly = 5; ramp_en = 0;
    do_reset();
    clear_stamps();
    pulse_start();
    repeat (30) @(negedge clk);
    chk(pwrdn == 2'b11, "R3 mid-wait power-down", pwrdn, 3);
    do_reset();
    check_idle("R1 reset mid-sequence");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule